// File: doc/BRIEF.md
# Alarm-Driven Restart Controller

This block watches a set of health flags for a small processor and keeps that processor in restart for as long as any of them is active. Six flags come from external voltage comparators. Each of the two regulated supplies has an over-limit flag and an under-limit flag. Each of the two main bus feeds has an under-limit flag. A seventh condition is detected inside the block: a memory read word that fails its odd-parity check. The comparators themselves are outside the block. Their results arrive as digital levels.

While restart is held, the processor is stalled. When the block releases restart, it injects a single transfer-control instruction aimed at the fixed start address (octal 4000). The processor then begins execution there. Restart is level driven and never latches. If an alarm is still present at the end of a minimum hold window, a fresh restart round begins. Once every condition has gone away, the block releases by itself. A maintenance inhibit input masks every condition. A restart counter is exposed for diagnostics.

Top module: `restart_ctrl`

## Requirements
- R1: During reset, `restart_active` is 1, `forced_valid` is 0 and `restart_count` is 0. After reset is removed with no alarm present, the block completes one restart sequence and then releases. This power-on sequence does not increment the count.
- R2: `forced_word` carries the branch word.
  - Bits 14:12 hold opcode 000, meaning transfer control.
  - Bits 11:0 hold the address 4000 octal.
  - Bit 15 is set so that the total number of ones across the word is odd.
  - With the defaults this is 16'h0800.
- R3: A supply flag (`sup1_over`, `sup1_under`, `sup2_over`, `sup2_under`) at 1, unmasked, puts the block in restart. Restart stays held for as long as the flag stays at 1.
- R4: A bus flag (`bus_a_low`, `bus_b_low`) at 1, unmasked, puts the block in restart in the same way.
- R5: A cycle with `rd_valid` = 1 and an even number of ones across all 16 bits of `rd_word` raises a parity alarm, and restart follows. A word with an odd count of ones causes no restart.
- R6: Every restart round holds for at least 8 cycles (MIN_HOLD) before release is evaluated. A round triggered by an alarm that has already cleared keeps `restart_active` high for exactly 9 cycles: 8 hold cycles plus 1 launch cycle.
- R7: `restart_count` increments by exactly 1 in each of these cases, and wraps at its width:
  - on every entry into restart from run;
  - on every new round started because an alarm is still active at the end of a hold window.
- R8: Once all alarms clear, the block releases by itself within 12 cycles. No reset is needed.
- R9: `maint_inhibit` = 1 masks all supply, bus and parity alarms, so no restart is entered. Removing it while an alarm is present lets that alarm act.
- R10: On each release, `forced_valid` is 1 for exactly one cycle, while `restart_active` is 1. In the following cycle `restart_active` is 0.
- R11: Flags and inhibit pass through a two-flop synchronizer. A flag driven between clock edges reaches `restart_active` on the third rising edge after it was driven, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sup1_over | input | 1 | Supply 1 above its window |
| sup1_under | input | 1 | Supply 1 below its window |
| sup2_over | input | 1 | Supply 2 above its window |
| sup2_under | input | 1 | Supply 2 below its window |
| bus_a_low | input | 1 | Main bus feed A under its minimum |
| bus_b_low | input | 1 | Main bus feed B under its minimum |
| rd_valid | input | 1 | Memory read word present this cycle |
| rd_word | input | 16 | Memory read word, 15 data bits plus parity in bit 15 |
| maint_inhibit | input | 1 | Masks every alarm condition when 1 |
| forced_word | output | 16 | Injected branch word, valid with forced_valid |
| forced_valid | output | 1 | One-cycle strobe for the injected branch |
| restart_active | output | 1 | Processor held in restart |
| restart_count | output | 8 | Number of restart entries and rounds since reset |

## Verification
The hardest situation to reach is the repeated restart round. It needs an alarm that is still present exactly when a hold window ends, together with a correct count step at that boundary. The stimulus holds a flag across several 8-cycle windows and checks that the count advances once per window. It also uses a single-cycle parity fault, which is gone long before the window ends, to measure the exact minimum hold. Randomly drawn flag and inhibit patterns, each held long enough to settle, cover inhibit release in the middle of an alarm and the transition from one alarm to another.

// File: rtl/rstc_pkg.sv
package rstc_pkg;

    typedef struct packed {
        logic s1_over;
        logic s1_under;
        logic s2_over;
        logic s2_under;
        logic bus_a_low;
        logic bus_b_low;
    } pwr_flags_t;

    localparam int PWR_FLAG_W = $bits(pwr_flags_t);

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_HOLD   = 2'd1,
        ST_LAUNCH = 2'd2
    } rst_state_t;

    localparam int TC_OPCODE = 0;

    function automatic logic any_power_alarm(input pwr_flags_t f);
        return f.s1_over | f.s1_under | f.s2_over | f.s2_under |
               f.bus_a_low | f.bus_b_low;
    endfunction

endpackage

// File: rtl/rstc_sync.sv
module rstc_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/rstc_parity.sv
module rstc_parity #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_valid,
    input  logic [WORD_W-1:0] rd_word,
    output logic              fault_q
);
    always_ff @(posedge clk) begin
        if (rst) fault_q <= 1'b0;
        else     fault_q <= rd_valid & ~(^rd_word);
    end
endmodule

// File: rtl/rstc_merge.sv
module rstc_merge
    import rstc_pkg::*;
(
    input  pwr_flags_t pwr,
    input  logic       parity_fault,
    input  logic       inhibit,
    output logic       alarm_any
);
    always_comb begin
        alarm_any = (any_power_alarm(pwr) | parity_fault) & ~inhibit;
    end
endmodule

// File: rtl/rstc_fsm.sv
module rstc_fsm
    import rstc_pkg::*;
#(
    parameter int              MIN_HOLD = 8,
    parameter int              CNT_W    = 8,
    parameter int              WORD_W   = 16,
    parameter logic [WORD_W-1:0] BR_WORD = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              alarm,
    output logic [WORD_W-1:0] forced_word,
    output logic              forced_valid,
    output logic              restart_active,
    output logic [CNT_W-1:0]  restart_count
);
    localparam int TMR_W = (MIN_HOLD > 1) ? $clog2(MIN_HOLD) : 1;
    localparam logic [TMR_W-1:0] LAST = TMR_W'(MIN_HOLD - 1);

    rst_state_t       state, state_n;
    logic [TMR_W-1:0] timer, timer_n;
    logic             enter;

    always_comb begin
        state_n = state;
        enter   = 1'b0;
        case (state)
            ST_RUN: begin
                if (alarm) begin
                    state_n = ST_HOLD;
                    enter   = 1'b1;
                end
            end
            ST_HOLD: begin
                if (timer == LAST) begin
                    if (alarm) begin
                        state_n = ST_HOLD;
                        enter   = 1'b1;
                    end else begin
                        state_n = ST_LAUNCH;
                    end
                end
            end
            ST_LAUNCH: state_n = ST_RUN;
            default:   state_n = ST_HOLD;
        endcase
        if (enter)                 timer_n = '0;
        else if (state == ST_HOLD) timer_n = timer + 1'b1;
        else                       timer_n = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state         <= ST_HOLD;
            timer         <= '0;
            restart_count <= '0;
        end else begin
            state <= state_n;
            timer <= timer_n;
            if (enter) restart_count <= restart_count + 1'b1;
        end
    end

    assign restart_active = (state != ST_RUN);
    assign forced_valid   = (state == ST_LAUNCH);
    assign forced_word    = forced_valid ? BR_WORD : '0;
endmodule

// File: rtl/restart_ctrl.sv
module restart_ctrl
    import rstc_pkg::*;
#(
    parameter int                DATA_W      = 15,
    parameter int                ADDR_W      = 12,
    parameter logic [ADDR_W-1:0] START_ADDR  = 12'o4000,
    parameter int                MIN_HOLD    = 8,
    parameter int                CNT_W       = 8,
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sup1_over,
    input  logic              sup1_under,
    input  logic              sup2_over,
    input  logic              sup2_under,
    input  logic              bus_a_low,
    input  logic              bus_b_low,
    input  logic              rd_valid,
    input  logic [DATA_W:0]   rd_word,
    input  logic              maint_inhibit,
    output logic [DATA_W:0]   forced_word,
    output logic              forced_valid,
    output logic              restart_active,
    output logic [CNT_W-1:0]  restart_count
);
    localparam int WORD_W = DATA_W + 1;
    localparam int OPC_W  = DATA_W - ADDR_W;
    localparam int SYN_W  = PWR_FLAG_W + 1;
    localparam logic [DATA_W-1:0] BR_DATA = {OPC_W'(TC_OPCODE), START_ADDR};
    localparam logic [WORD_W-1:0] BR_WORD = {~(^BR_DATA), BR_DATA};

    pwr_flags_t       pwr_raw, pwr_s;
    logic             inhibit_s;
    logic             parity_fault;
    logic             alarm_any;
    logic [SYN_W-1:0] syn_q;

    always_comb begin
        pwr_raw.s1_over   = sup1_over;
        pwr_raw.s1_under  = sup1_under;
        pwr_raw.s2_over   = sup2_over;
        pwr_raw.s2_under  = sup2_under;
        pwr_raw.bus_a_low = bus_a_low;
        pwr_raw.bus_b_low = bus_b_low;
    end

    rstc_sync #(.W(SYN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({maint_inhibit, pwr_raw}),
        .q   (syn_q)
    );

    assign pwr_s     = pwr_flags_t'(syn_q[PWR_FLAG_W-1:0]);
    assign inhibit_s = syn_q[SYN_W-1];

    rstc_parity #(.WORD_W(WORD_W)) u_par (
        .clk      (clk),
        .rst      (rst),
        .rd_valid (rd_valid),
        .rd_word  (rd_word),
        .fault_q  (parity_fault)
    );

    rstc_merge u_merge (
        .pwr          (pwr_s),
        .parity_fault (parity_fault),
        .inhibit      (inhibit_s),
        .alarm_any    (alarm_any)
    );

    rstc_fsm #(
        .MIN_HOLD (MIN_HOLD),
        .CNT_W    (CNT_W),
        .WORD_W   (WORD_W),
        .BR_WORD  (BR_WORD)
    ) u_fsm (
        .clk            (clk),
        .rst            (rst),
        .alarm          (alarm_any),
        .forced_word    (forced_word),
        .forced_valid   (forced_valid),
        .restart_active (restart_active),
        .restart_count  (restart_count)
    );
endmodule

// File: rtl/rstc_checker.sv
module rstc_checker #(
    parameter int MIN_HOLD = 8,
    parameter int CNT_W    = 8,
    parameter int WORD_W   = 16
) (
    input logic              clk,
    input logic              rst,
    input logic [WORD_W-1:0] forced_word,
    input logic              forced_valid,
    input logic              restart_active,
    input logic [CNT_W-1:0]  restart_count
);
    logic [31:0] run_len;

    always_ff @(posedge clk) begin
        if (rst)                 run_len <= '0;
        else if (!restart_active) run_len <= '0;
        else if (run_len != '1)  run_len <= run_len + 1'b1;
    end

    AST_LAUNCH_IN_RESTART: assert property (@(posedge clk) disable iff (rst)
        forced_valid |-> restart_active); // R10

    AST_LAUNCH_THEN_RUN: assert property (@(posedge clk) disable iff (rst)
        forced_valid |=> (!restart_active && !forced_valid)); // R10

    AST_WORD_ODD: assert property (@(posedge clk) disable iff (rst)
        forced_valid |-> (^forced_word)); // R2

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (restart_count != $past(restart_count)) |->
        (restart_count == $past(restart_count) + 1'b1)); // R7

    AST_ENTRY_COUNTED: assert property (@(posedge clk) disable iff (rst)
        $rose(restart_active) |->
        (restart_count == $past(restart_count) + 1'b1)); // R7

    AST_MIN_HOLD: assert property (@(posedge clk) disable iff (rst)
        $fell(restart_active) |-> (run_len > MIN_HOLD)); // R6
endmodule

bind restart_ctrl rstc_checker #(
    .MIN_HOLD (MIN_HOLD),
    .CNT_W    (CNT_W),
    .WORD_W   (WORD_W)
) u_chk (
    .clk            (clk),
    .rst            (rst),
    .forced_word    (forced_word),
    .forced_valid   (forced_valid),
    .restart_active (restart_active),
    .restart_count  (restart_count)
);

// File: tb/restart_ctrl_test.sv
`timescale 1ns/1ps
module restart_ctrl_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  flags = '0;
    logic        rd_valid = 1'b0;
    logic [15:0] rd_word = '0;
    logic        inh = 1'b0;
    logic [15:0] forced_word;
    logic        forced_valid;
    logic        restart_active;
    logic [7:0]  restart_count;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    restart_ctrl uut (
        .clk            (clk),
        .rst            (rst),
        .sup1_over      (flags[5]),
        .sup1_under     (flags[4]),
        .sup2_over      (flags[3]),
        .sup2_under     (flags[2]),
        .bus_a_low      (flags[1]),
        .bus_b_low      (flags[0]),
        .rd_valid       (rd_valid),
        .rd_word        (rd_word),
        .maint_inhibit  (inh),
        .forced_word    (forced_word),
        .forced_valid   (forced_valid),
        .restart_active (restart_active),
        .restart_count  (restart_count)
    );

    function automatic logic [15:0] exp_branch();
        logic [14:0] d;
        d = {3'b000, 12'o4000};
        return {~(^d), d};
    endfunction

    function automatic bit exp_restart(input logic [5:0] f, input logic i);
        return (|f) && !i;
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    endtask

    // wait for release, return cycles taken and launch pulses seen
    task automatic wait_release(output int cyc, output int pulses);
        cyc = 0;
        pulses = 0;
        for (int k = 0; k < 40; k++) begin
            if (!restart_active) break;
            if (forced_valid) pulses++;
            tick(1);
            cyc++;
        end
    endtask

    initial begin
        #(4 * 150000);
        n_err++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int cyc, pulses, c0, len;
        logic [5:0] f;
        logic       i;
        void'($urandom(32'd20240611));

        tick(5);
        chk(restart_active == 1'b1, "R1 reset active", restart_active, 1);
        chk(forced_valid == 1'b0, "R1 reset strobe", forced_valid, 0);
        chk(restart_count == 8'd0, "R1 reset count", restart_count, 0);

        rst = 1'b0;
        cyc = 0;
        for (int k = 1; k <= 40; k++) begin
            tick(1);
            if (forced_valid) begin cyc = k; break; end
        end
        chk(cyc == 8, "R6 power-on hold length", cyc, 8);
        chk(forced_word == exp_branch(), "R2 branch word", forced_word, exp_branch());
        tick(1);
        chk(restart_active == 1'b0, "R10 run after launch", restart_active, 0);
        chk(restart_count == 8'd0, "R1 power-on not counted", restart_count, 0);

        // R11 latency and R3 supply alarm
        flags[5] = 1'b1;
        tick(2);
        chk(restart_active == 1'b0, "R11 not before third edge", restart_active, 0);
        tick(1);
        chk(restart_active == 1'b1, "R11 third edge", restart_active, 1);
        chk(restart_count == 8'd1, "R7 entry count", restart_count, 1);
        tick(40);
        chk(restart_active == 1'b1, "R3 held while alarm persists", restart_active, 1);
        chk(restart_count >= 8'd5 && restart_count <= 8'd7, "R7 repeated rounds",
            restart_count, 6);
        flags = '0;
        wait_release(cyc, pulses);
        chk(cyc <= 12, "R8 self release", cyc, 12);
        chk(pulses == 1, "R10 one launch per release", pulses, 1);

        // R4 bus under
        c0 = restart_count;
        flags[0] = 1'b1;
        tick(3);
        chk(restart_active == 1'b1, "R4 bus low restart", restart_active, 1);
        chk(restart_count == 8'(c0 + 1), "R7 bus entry count", restart_count, c0 + 1);
        flags = '0;
        wait_release(cyc, pulses);
        chk(cyc <= 12, "R8 bus release", cyc, 12);

        // R5 parity good word: odd ones
        c0 = restart_count;
        rd_word = 16'h0001; rd_valid = 1'b1;
        tick(1);
        rd_valid = 1'b0;
        tick(15);
        chk(restart_active == 1'b0, "R5 odd word ignored", restart_active, 0);
        chk(restart_count == 8'(c0), "R5 odd word no count", restart_count, c0);

        // R5/R6 parity bad word, exact length
        rd_word = 16'h0003; rd_valid = 1'b1;
        tick(1);
        rd_valid = 1'b0;
        for (int k = 0; k < 5; k++) begin
            if (restart_active) break;
            tick(1);
        end
        chk(restart_active == 1'b1, "R5 even word restart", restart_active, 1);
        len = 0;
        for (int k = 0; k < 40; k++) begin
            if (!restart_active) break;
            len++;
            tick(1);
        end
        chk(len == 9, "R6 exact hold plus launch", len, 9);

        // R9 inhibit masks everything
        inh = 1'b1;
        tick(4);
        c0 = restart_count;
        flags[2] = 1'b1;
        rd_word = 16'h0000; rd_valid = 1'b1;
        tick(1);
        rd_valid = 1'b0;
        tick(20);
        chk(restart_active == 1'b0, "R9 inhibit masks", restart_active, 0);
        chk(restart_count == 8'(c0), "R9 inhibit no count", restart_count, c0);
        inh = 1'b0;
        tick(4);
        chk(restart_active == 1'b1, "R9 inhibit removed", restart_active, 1);
        flags = '0;
        wait_release(cyc, pulses);
        chk(cyc <= 12, "R8 release after inhibit test", cyc, 12);

        // random patterns held long enough to settle
        for (int it = 0; it < 40; it++) begin
            f = 6'($urandom);
            if ($urandom % 3 == 0) f = '0;
            i = ($urandom % 4 == 0);
            c0 = restart_count;
            flags = f;
            inh = i;
            tick(30);
            chk(restart_active == exp_restart(f, i), "R3 R4 R9 R8 random pattern",
                restart_active, exp_restart(f, i));
            if (exp_restart(f, i))
                chk(restart_count != 8'(c0), "R7 random count advance", restart_count, c0 + 1);
        end

        finish_run();
    end
endmodule